// File: doc/BRIEF.md
# Microsecond Time Base with Coherent Split-Word Access

A 64-bit time counter that advances by one on every cycle in which a one-microsecond tick enable is high, so that after reset it holds the microseconds elapsed. Software reaches it through a 32-bit register port. Each 64-bit read or write is done as two word accesses, and hardware keeps each pair consistent.

A write to the low write register is held in a staging register. The live count changes only when the high write register is written, and then all 64 bits load at once. A read of the low latched-read register captures the upper half into a holding register. The following read of the high latched-read register returns that captured value, so a carry between the two reads cannot tear the result. Two raw registers return the live halves with no side effects. Counting can be stopped by a software pause bit. It can also be stopped by any debug-halt input whose enable bit is set. The low word of the live count is driven out every cycle for an alarm comparator.

Top module: `usec_timebase`

## Requirements
- R1: After reset the count, staging register and holding register are zero, the pause bit and all debug-pause enables are clear, and every readable register returns zero.
- R2: The count increases by exactly one at each clock edge where `tick_i` is high and no pause condition holds. It stays unchanged when `tick_i` is low.
- R3: A write to address 0 (low write) stores the data in the staging register and leaves the live count unchanged.
- R4: A write to address 1 (high write) loads the count with {write data, staged low word} at that clock edge. The loaded value is visible from the next cycle.
- R5: When a high write and a tick occur in the same cycle, the loaded value wins and is not incremented.
- R6: A read of address 2 (latched low) returns live bits 31:0 in the same cycle. At that clock edge it copies live bits 63:32 into the holding register.
- R7: A read of address 3 (latched high) returns the holding register, not the live upper half.
- R8: Reads of address 4 and address 5 return the live bits 31:0 and 63:32. They do not change the holding register.
- R9: Bit 0 of address 6 is the pause bit. It reads back, and while it is set the count does not advance.
- R10: Bits [N_DBG-1:0] of address 7 are debug-pause enables and read back. The count stops only while some bit i is set and `dbg_halt_i[i]` is high. A set enable with its halt low, or a high halt with its enable clear, does not stop it.
- R11: `time_lo_o` equals live bits 31:0 in every cycle.
- R12: An increment from a low word of 0xFFFFFFFF carries into the upper half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Register access strobe, one access per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational for the current request |
| tick_i | input | 1 | One-microsecond count enable |
| dbg_halt_i | input | N_DBG (2) | Debug-halt inputs, one per debug port |
| time_lo_o | output | 32 | Live low word of the count for alarm comparison |

## Verification
A wrong count shows on `time_lo_o` in the cycle after the bad edge and on the raw reads at once, so the bench checks exact values after a known number of ticks. Staging or holding faults stay hidden until the matching second access: a bad staged word shows only when the high write loads, and a bad holding value shows only on the latched-high read. The bench therefore places a carry between the two reads, so that holding and live upper halves differ. It also confirms that raw reads leave the holding value alone.

// File: rtl/usec_tb_pkg.sv
package usec_timebase_pkg;
  localparam int HALF_W = 32;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_WR_LO  = 3'd0;
  localparam logic [ADDR_W-1:0] A_WR_HI  = 3'd1;
  localparam logic [ADDR_W-1:0] A_LAT_LO = 3'd2;
  localparam logic [ADDR_W-1:0] A_LAT_HI = 3'd3;
  localparam logic [ADDR_W-1:0] A_RAW_LO = 3'd4;
  localparam logic [ADDR_W-1:0] A_RAW_HI = 3'd5;
  localparam logic [ADDR_W-1:0] A_PAUSE  = 3'd6;
  localparam logic [ADDR_W-1:0] A_DBGEN  = 3'd7;
endpackage

// File: rtl/usec_count_core.sv
module usec_count_core #(
  parameter int CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;

  // load has priority over increment
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (inc_i)  cnt_q <= cnt_q + ONE;
  end

  assign cnt_o = cnt_q;

  a_r4_load_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(load_val_i));
  a_r2_step_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && inc_i) |=> cnt_q == $past(cnt_q) + ONE);
  a_r2_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !inc_i) |=> $stable(cnt_q));
endmodule

// File: rtl/usec_split_access.sv
module usec_split_access #(
  parameter int HALF_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_lo_i,
  input  logic              rd_lo_i,
  input  logic [HALF_W-1:0] wdata_i,
  input  logic [HALF_W-1:0] cnt_hi_i,
  output logic [HALF_W-1:0] stage_o,
  output logic [HALF_W-1:0] hold_o
);
  logic [HALF_W-1:0] stage_q, hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      stage_q <= '0;
    else if (wr_lo_i) stage_q <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hold_q <= '0;
    else if (rd_lo_i) hold_q <= cnt_hi_i;
  end

  assign stage_o = stage_q;
  assign hold_o  = hold_q;

  a_r3_stage_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo_i |=> stage_q == $past(wdata_i));
  a_r6_hold_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_lo_i |=> hold_q == $past(cnt_hi_i));
  a_r8_hold_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_lo_i |=> $stable(hold_q));
endmodule

// File: rtl/usec_pause_ctrl.sv
module usec_pause_ctrl #(
  parameter int N_DBG = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_pause_i,
  input  logic             wr_dbgen_i,
  input  logic             pause_d_i,
  input  logic [N_DBG-1:0] dbgen_d_i,
  input  logic [N_DBG-1:0] dbg_halt_i,
  output logic             pause_o,
  output logic [N_DBG-1:0] dbgen_o,
  output logic             halt_o
);
  logic             pause_q;
  logic [N_DBG-1:0] dbgen_q;
  logic [N_DBG-1:0] port_stop;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pause_q <= 1'b0;
      dbgen_q <= '0;
    end else begin
      if (wr_pause_i) pause_q <= pause_d_i;
      if (wr_dbgen_i) dbgen_q <= dbgen_d_i;
    end
  end

  for (genvar i = 0; i < N_DBG; i++) begin : g_port
    assign port_stop[i] = dbgen_q[i] & dbg_halt_i[i];
  end

  assign halt_o  = pause_q | (|port_stop);
  assign pause_o = pause_q;
  assign dbgen_o = dbgen_q;

  a_r10_dbgen_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_dbgen_i |=> dbgen_q == $past(dbgen_d_i));
  a_r9_pause_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_pause_i |=> pause_q == $past(pause_d_i));
endmodule

// File: rtl/usec_timebase.sv
module usec_timebase
  import usec_timebase_pkg::*;
#(
  parameter int N_DBG = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [HALF_W-1:0] wdata_i,
  output logic [HALF_W-1:0] rdata_o,
  input  logic              tick_i,
  input  logic [N_DBG-1:0]  dbg_halt_i,
  output logic [HALF_W-1:0] time_lo_o
);
  localparam int CNT_W = 2 * HALF_W;

  logic              wr, rd;
  logic              wr_lo, wr_hi, rd_lo, wr_pause, wr_dbgen;
  logic [CNT_W-1:0]  cnt;
  logic [HALF_W-1:0] stage, hold;
  logic              pause, halt, inc;
  logic [N_DBG-1:0]  dbgen;

  assign wr       = req_i & we_i;
  assign rd       = req_i & ~we_i;
  assign wr_lo    = wr & (addr_i == A_WR_LO);
  assign wr_hi    = wr & (addr_i == A_WR_HI);
  assign wr_pause = wr & (addr_i == A_PAUSE);
  assign wr_dbgen = wr & (addr_i == A_DBGEN);
  assign rd_lo    = rd & (addr_i == A_LAT_LO);
  assign inc      = tick_i & ~halt;

  usec_pause_ctrl #(.N_DBG(N_DBG)) u_pause (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_pause_i (wr_pause),
    .wr_dbgen_i (wr_dbgen),
    .pause_d_i  (wdata_i[0]),
    .dbgen_d_i  (wdata_i[N_DBG-1:0]),
    .dbg_halt_i (dbg_halt_i),
    .pause_o    (pause),
    .dbgen_o    (dbgen),
    .halt_o     (halt)
  );

  usec_split_access #(.HALF_W(HALF_W)) u_split (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_lo_i  (wr_lo),
    .rd_lo_i  (rd_lo),
    .wdata_i  (wdata_i),
    .cnt_hi_i (cnt[CNT_W-1:HALF_W]),
    .stage_o  (stage),
    .hold_o   (hold)
  );

  usec_count_core #(.CNT_W(CNT_W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (wr_hi),
    .load_val_i ({wdata_i, stage}),
    .inc_i      (inc),
    .cnt_o      (cnt)
  );

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      unique case (addr_i)
        A_LAT_LO, A_RAW_LO: rdata_o = cnt[HALF_W-1:0];
        A_LAT_HI:           rdata_o = hold;
        A_RAW_HI:           rdata_o = cnt[CNT_W-1:HALF_W];
        A_PAUSE:            rdata_o[0] = pause;
        A_DBGEN:            rdata_o[N_DBG-1:0] = dbgen;
        default:            rdata_o = '0;
      endcase
    end
  end

  assign time_lo_o = cnt[HALF_W-1:0];

  a_r3_lo_write_no_effect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_lo && !tick_i) |=> $stable(time_lo_o));
  a_r9_paused_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pause && !wr_hi) |=> $stable(cnt));
  a_r5_load_beats_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hi && tick_i) |=> cnt[CNT_W-1:HALF_W] == $past(wdata_i));
endmodule

// File: tb/usec_timebase_tb.sv
module usec_timebase_tb;
  import usec_timebase_pkg::*;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req = 1'b0, we = 1'b0, tick = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata, time_lo;
  logic [1:0]        halt = '0;
  int                checks = 0, errors = 0;
  bit                done = 1'b0;

  always #2.5 clk = ~clk;

  usec_timebase #(.N_DBG(2)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tick_i(tick), .dbg_halt_i(halt),
    .time_lo_o(time_lo)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    #1 d = rdata;
    @(negedge clk); req = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
    end
    @(negedge clk); tick = 0;
  endtask

  task automatic load64(input logic [31:0] hi, input logic [31:0] lo);
    wr(A_WR_LO, lo);
    wr(A_WR_HI, hi);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(A_RAW_LO, d); chk("R1 raw lo", d, 0);
    rd(A_RAW_HI, d); chk("R1 raw hi", d, 0);
    rd(A_LAT_HI, d); chk("R1 hold", d, 0);
    rd(A_PAUSE, d);  chk("R1 pause", d, 0);
    rd(A_DBGEN, d);  chk("R1 dbgen", d, 0);
    wr(A_WR_HI, 32'h7);
    rd(A_RAW_LO, d); chk("R1 stage zero", d, 0);
  endtask

  task automatic t_count();
    logic [31:0] d;
    load64(32'h0, 32'h10);
    ticks(5);
    rd(A_RAW_LO, d); chk("R2 five ticks", d, 32'h15);
    repeat (3) @(negedge clk);
    chk("R2 no tick", time_lo, 32'h15);
    chk("R11 export", time_lo, 32'h15);
  endtask

  task automatic t_stage();
    logic [31:0] d;
    load64(32'h0, 32'h100);
    wr(A_WR_LO, 32'hdead_beef);
    chk("R3 live unchanged", time_lo, 32'h100);
    rd(A_RAW_HI, d); chk("R3 hi unchanged", d, 0);
    wr(A_WR_HI, 32'h1234_5678);
    rd(A_RAW_LO, d); chk("R4 lo loaded", d, 32'hdead_beef);
    rd(A_RAW_HI, d); chk("R4 hi loaded", d, 32'h1234_5678);
  endtask

  task automatic t_load_vs_tick();
    logic [31:0] d;
    wr(A_WR_LO, 32'h55);
    @(negedge clk); req = 1; we = 1; addr = A_WR_HI; wdata = 32'h9; tick = 1;
    @(negedge clk); req = 0; we = 0; tick = 0;
    rd(A_RAW_LO, d); chk("R5 lo not incremented", d, 32'h55);
    rd(A_RAW_HI, d); chk("R5 hi", d, 32'h9);
  endtask

  task automatic t_latch();
    logic [31:0] d;
    load64(32'h1, 32'hffff_ffff);
    rd(A_LAT_LO, d); chk("R6 latched lo", d, 32'hffff_ffff);
    ticks(1);
    chk("R12 lo wraps", time_lo, 0);
    rd(A_RAW_HI, d); chk("R12 carry", d, 32'h2);
    rd(A_LAT_HI, d); chk("R7 held hi", d, 32'h1);
    rd(A_RAW_LO, d); chk("R8 raw lo", d, 0);
    rd(A_LAT_HI, d); chk("R8 hold kept", d, 32'h1);
    rd(A_LAT_LO, d); chk("R6 relatch lo", d, 0);
    rd(A_LAT_HI, d); chk("R6 relatch hi", d, 32'h2);
  endtask

  task automatic t_pause();
    logic [31:0] d;
    load64(32'h0, 32'h20);
    wr(A_PAUSE, 32'h1);
    rd(A_PAUSE, d); chk("R9 readback", d, 32'h1);
    ticks(4);
    chk("R9 frozen", time_lo, 32'h20);
    wr(A_PAUSE, 32'h0);
    ticks(2);
    chk("R9 resumed", time_lo, 32'h22);
  endtask

  task automatic t_dbg();
    logic [31:0] d;
    load64(32'h0, 32'h40);
    wr(A_DBGEN, 32'h2);
    rd(A_DBGEN, d); chk("R10 readback", d, 32'h2);
    halt = 2'b01; ticks(3);
    chk("R10 unenabled halt ignored", time_lo, 32'h43);
    halt = 2'b10; ticks(3);
    chk("R10 enabled halt stops", time_lo, 32'h43);
    halt = 2'b00; ticks(2);
    chk("R10 enabled no halt counts", time_lo, 32'h45);
    wr(A_DBGEN, 32'h0);
    halt = 2'b11; ticks(1);
    chk("R10 disabled", time_lo, 32'h46);
    halt = 2'b00;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_count();
    t_stage();
    t_load_vs_tick();
    t_latch();
    t_pause();
    t_dbg();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule